// File: doc/BRIEF.md
# Phase-Alignable Tone and Noise Generator Core

This core makes four 1-bit sound levels: three square-wave tone channels and one pseudo-random noise channel. Each tone channel has a 12-bit reload counter that is stepped by a shared clock-enable tick, and the counter sets the pitch. A sync register holds one bit per channel. While a tone channel's sync bit is set, its square wave is held low and its counter stays loaded with the reload value. Clearing the sync bits starts all released counters together, so channels begin with a known phase relation. A pitch change while a channel runs keeps its phase, so one channel can be moved against another by running it fast for a short time and then setting the pitches equal again.

Any tone channel can be ring-modulated, which replaces its level with the XNOR of its own square wave and a partner's level. Channels 0 and 2 are partners of each other. Channel 1's partner is the noise level. The noise channel is a 17-bit maximal-length shift register that steps on each rising edge of a selected tone channel's final level. Software can use this path to force the noise level to 1: it holds channel 1 low and selects it as the noise clock, then switches channel 1's ring modulation on and off many times.

Registers are written through a byte-wide address/data port. Volume, mixing and conversion belong to the blocks that follow this one.

Top module: `tone_sync_ring_core`

## Requirements
- R1: After reset all reload, control and sync registers are zero, the shift register holds 1, and chan_lvl reads 0000.
- R2: Address 2k writes bits 7:0 and address 2k+1 writes bits 11:8 (data bits 3:0) of tone channel k's reload value R. Each tick decrements the counter. A tick that finds the counter at zero reloads R and inverts the square wave. With a tick every cycle, the first inversion comes R+1 cycles after release and later inversions come every R+1 cycles.
- R3: While tick_en is low, no tone counter or square wave changes.
- R4: Address 7 bits 0..3 are the sync bits of channels 0..3. A set bit holds that tone's square wave at 0 and its counter at R. Writing 0 releases every channel on the same edge, so released channels with equal R produce identical waveforms.
- R5: Writing a new reload value while a channel runs does not restart the count in progress. The new value first applies at the next reload.
- R6: Address 6 bits 0..2 enable ring modulation on channels 0..2. With ring modulation on, channel 0's level is XNOR(square0, square2) and channel 2's level is XNOR(square2, square0).
- R7: With ring modulation on, channel 1's level is XNOR(square1, noise level). With channel 1 synced, chan_lvl[1] is the inverse of chan_lvl[3].
- R8: The noise register s steps as s <= {s[15:0], s[16]^s[13]}, and chan_lvl[3] = s[16]. It steps one cycle after a rising edge of the source that address 6 bits 5:4 select: 0 for channel 0, 1 for channel 1, 2 for channel 2 (the levels after ring modulation), 3 for none.
- R9: The noise register holds its value when the selected source does not rise. This covers select 3, a synced source with ring modulation off, and sync bit 3 set, which freezes the noise register.
- R10: With channels 1 and 2 synced and channel 1 selected, more than 17 on/off cycles of channel 1's ring enable leave the noise level at 1. The level then stays at 1 when the source moves to channel 2 and when ring modulation is switched on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock enable that steps the tone counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| chan_lvl | output | 4 | Levels of tone channels 0..2 (after ring modulation) and the noise channel in bit 3 |

## Verification
The assertions check the local rules on every cycle. A synced channel is low and loaded with its reload value one edge later. Without a tick nothing moves. A square wave inverts only on a tick that finds the counter at zero. The noise register never reaches zero and holds without a source rise. A synced, ring-modulated channel 1 is the inverse of the noise level. The bench scenarios cover the behaviour that builds up over many cycles: exact periods, the in-phase release of two channels, the delayed effect of a mid-count reload change, ring products of two running waves, the full noise sequence against an independent model, and the force-to-one procedure.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int NUM_TONE = 3;
  localparam int NUM_CHAN = NUM_TONE + 1;
  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_SYNC = 3'd7;
  localparam int CTRL_SEL_LSB = 4;

  typedef enum logic [1:0] {
    NSRC_CH0 = 2'd0,
    NSRC_CH1 = 2'd1,
    NSRC_CH2 = 2'd2,
    NSRC_OFF = 2'd3
  } nsrc_e;
endpackage

// File: rtl/tsr_regs.sv
module tsr_regs
  import tsr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [7:0]                      wr_data,
  output logic [NUM_TONE-1:0][CNT_W-1:0]  reload_o,
  output logic [NUM_TONE-1:0]             ring_o,
  output nsrc_e                           nsel_o,
  output logic [NUM_CHAN-1:0]             sync_o
);
  localparam int HI_W = CNT_W - 8;

  for (genvar k = 0; k < NUM_TONE; k++) begin : g_reload
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * k + 1);
    logic [CNT_W-1:0] rl_q, rl_d;

    always_comb begin
      rl_d = rl_q;
      if (wr_en && wr_addr == LO_ADDR) rl_d[7:0] = wr_data;
      if (wr_en && wr_addr == HI_ADDR) rl_d[CNT_W-1:8] = wr_data[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rl_q <= '0;
      else        rl_q <= rl_d;
    end

    assign reload_o[k] = rl_q;
  end

  logic [NUM_TONE-1:0] ring_q, ring_d;
  nsrc_e               nsel_q, nsel_d;
  logic [NUM_CHAN-1:0] sync_q, sync_d;

  always_comb begin
    ring_d = ring_q;
    nsel_d = nsel_q;
    sync_d = sync_q;
    if (wr_en && wr_addr == ADDR_CTRL) begin
      ring_d = wr_data[NUM_TONE-1:0];
      nsel_d = nsrc_e'(wr_data[CTRL_SEL_LSB +: 2]);
    end
    if (wr_en && wr_addr == ADDR_SYNC) sync_d = wr_data[NUM_CHAN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0;
      nsel_q <= NSRC_CH0;
      sync_q <= '0;
    end else begin
      ring_q <= ring_d;
      nsel_q <= nsel_d;
      sync_q <= sync_d;
    end
  end

  assign ring_o = ring_q;
  assign nsel_o = nsel_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/tsr_tone_chan.sv
module tsr_tone_chan #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             sq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sq_q, sq_d;

  always_comb begin
    cnt_d = cnt_q;
    sq_d  = sq_q;
    if (sync_i) begin
      cnt_d = reload_i;
      sq_d  = 1'b0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = reload_i;
        sq_d  = ~sq_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
    end
  end

  assign sq_o = sq_q;

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (sq_q == 1'b0 && cnt_q == $past(reload_i)));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !sync_i) |=> ($stable(sq_q) && $stable(cnt_q)));

  // R2
  toggle_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !sync_i && cnt_q != '0) |=> $stable(sq_q));
endmodule

// File: rtl/tsr_noise.sv
module tsr_noise #(
  parameter int LFSR_W   = 17,
  parameter int LFSR_TAP = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic frz_i,
  output logic lvl_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              prev_q;
  logic              step;

  assign step = src_i && !prev_q && !frz_i;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step) lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_W'(1);
      prev_q <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      prev_q <= src_i;
    end
  end

  assign lvl_o = lfsr_q[LFSR_W-1];

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R9
  no_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_i || prev_q || frz_i) |=> $stable(lfsr_q));
endmodule

// File: rtl/tone_sync_ring_core.sv
module tone_sync_ring_core
  import tsr_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LFSR_W   = 17,
  parameter int LFSR_TAP = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CHAN-1:0] chan_lvl
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NUM_TONE-1:0][CNT_W-1:0] reload;
  logic [NUM_TONE-1:0]            ring;
  nsrc_e                          nsel;
  logic [NUM_CHAN-1:0]            sync;
  logic [NUM_TONE-1:0]            sq;
  logic                           noise_lvl;
  logic                           noise_src;

  tsr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .reload_o (reload),
    .ring_o   (ring),
    .nsel_o   (nsel),
    .sync_o   (sync)
  );

  for (genvar k = 0; k < NUM_TONE; k++) begin : g_tone
    tsr_tone_chan #(.CNT_W(CNT_W)) u_tone (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .tick_i   (tick_en),
      .sync_i   (sync[k]),
      .reload_i (reload[k]),
      .sq_o     (sq[k])
    );
  end

  // Ring partners: 0 <-> 2 (raw squares), 1 <-> noise level.
  always_comb begin
    chan_lvl[0] = ring[0] ? ~(sq[0] ^ sq[2])    : sq[0];
    chan_lvl[1] = ring[1] ? ~(sq[1] ^ noise_lvl) : sq[1];
    chan_lvl[2] = ring[2] ? ~(sq[2] ^ sq[0])    : sq[2];
    chan_lvl[3] = noise_lvl;
  end

  always_comb begin
    unique case (nsel)
      NSRC_CH0: noise_src = chan_lvl[0];
      NSRC_CH1: noise_src = chan_lvl[1];
      NSRC_CH2: noise_src = chan_lvl[2];
      default:  noise_src = 1'b0;
    endcase
  end

  tsr_noise #(.LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP)) u_noise (
    .clk   (clk),
    .rst_n (rst_core_n),
    .src_i (noise_src),
    .frz_i (sync[3]),
    .lvl_o (noise_lvl)
  );

  // R7
  ring_noise_inv_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sync[1] && $past(sync[1]) && ring[1]) |-> (chan_lvl[1] != chan_lvl[3]));
endmodule

// File: tb/tone_sync_ring_core_bench.sv
module tone_sync_ring_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] lvl;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tone_sync_ring_core u_tone_sync_ring_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .chan_lvl(lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Called at a negedge; the write commits on the next posedge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(lvl == 4'b0000, "R1 reset levels", lvl, 0);
  endtask

  task automatic t_freq();
    do_reset();
    wr(3'd0, 8'd4); wr(3'd1, 8'd0); wr(3'd7, 8'h01);
    tick_en = 1'b1;
    wr(3'd7, 8'h00);
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      chk(lvl[0] == 1'(((j / 5) % 2)), "R2 period R+1", lvl[0], (j / 5) % 2);
    end
    // R3: stop ticks, nothing moves
    tick_en = 1'b0;
    begin
      logic hold = lvl[0];
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        chk(lvl[0] == hold, "R3 no tick hold", lvl[0], hold);
      end
    end
  endtask

  task automatic t_sync();
    do_reset();
    wr(3'd0, 8'd3); wr(3'd4, 8'd3); wr(3'd7, 8'h05);
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(lvl[0] == 1'b0 && lvl[2] == 1'b0, "R4 held low", {30'd0, lvl[2], lvl[0]}, 0);
    wr(3'd7, 8'h00);
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      chk(lvl[0] == lvl[2], "R4 aligned release", lvl[0], lvl[2]);
      chk(lvl[0] == 1'(((j / 4) % 2)), "R4 phase after release", lvl[0], (j / 4) % 2);
    end
    // re-sync channel 0 while it runs high
    while (lvl[0] != 1'b1) @(negedge clk);
    wr(3'd7, 8'h01);
    @(negedge clk);
    chk(lvl[0] == 1'b0, "R4 resync forces low", lvl[0], 0);
  endtask

  task automatic t_reload();
    do_reset();
    wr(3'd0, 8'd9); wr(3'd7, 8'h01);
    tick_en = 1'b1;
    wr(3'd7, 8'h00);
    for (int j = 1; j <= 3; j++) @(negedge clk);
    wr(3'd0, 8'd3);           // commits on edge 4 after release
    for (int j = 5; j <= 25; j++) begin
      int e;
      @(negedge clk);
      e = (j < 10) ? 0 : ((((j - 10) / 4) % 2) == 0 ? 1 : 0);
      chk(lvl[0] == 1'(e), "R5 reload keeps phase", lvl[0], e);
    end
  endtask

  task automatic t_ring();
    do_reset();
    wr(3'd0, 8'd2); wr(3'd4, 8'd5);
    wr(3'd6, 8'h31);          // ring on ch0, noise source none
    wr(3'd7, 8'h05);
    tick_en = 1'b1;
    wr(3'd7, 8'h00);
    for (int j = 1; j <= 36; j++) begin
      int s0, s2, e0;
      @(negedge clk);
      s0 = (j / 3) % 2;
      s2 = (j / 6) % 2;
      e0 = (s0 == s2) ? 1 : 0;
      chk(lvl[0] == 1'(e0), "R6 ring XNOR ch0", lvl[0], e0);
      chk(lvl[2] == 1'(s2), "R6 ch2 unmodulated", lvl[2], s2);
    end
    wr(3'd7, 8'h05);
    @(negedge clk);
    chk(lvl[0] == 1'b1, "R6 XNOR of two lows", lvl[0], 1);
  endtask

  task automatic t_ring_noise();
    do_reset();
    wr(3'd6, 8'h32);          // ring on ch1, source none
    wr(3'd7, 8'h02);
    repeat (2) @(negedge clk);
    chk(lvl[1] == 1'b1, "R7 synced ch1 with noise 0", lvl[1], 1);
    chk(lvl[3] == 1'b0, "R7 noise still seed output", lvl[3], 0);
  endtask

  task automatic t_lfsr();
    logic [16:0] m;
    logic prevb;
    logic hold;
    int steps;
    do_reset();
    wr(3'd0, 8'd1); wr(3'd6, 8'h00);
    m = 17'd1; prevb = 1'b0; steps = 0;
    tick_en = 1'b1;
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      chk(lvl[3] == m[16], "R8 noise sequence", lvl[3], m[16]);
      if (lvl[0] && !prevb) begin
        m = {m[15:0], m[16] ^ m[13]};
        steps++;
      end
      prevb = lvl[0];
    end
    chk(steps > 40, "R8 source rises seen", steps, 41);
    // R9: freeze via sync bit 3
    wr(3'd7, 8'h08);
    repeat (2) @(negedge clk);
    hold = lvl[3];
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      chk(lvl[3] == hold, "R9 frozen by sync", lvl[3], hold);
    end
    // R9: source none
    wr(3'd6, 8'h30); wr(3'd7, 8'h00);
    hold = lvl[3];
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      chk(lvl[3] == hold, "R9 source none", lvl[3], hold);
    end
    // R9: synced ch2 with ring off as source
    wr(3'd7, 8'h04); wr(3'd4, 8'd0); wr(3'd6, 8'h20);
    hold = lvl[3];
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      chk(lvl[3] == hold, "R9 synced source", lvl[3], hold);
    end
  endtask

  task automatic t_find_one();
    do_reset();
    wr(3'd7, 8'h06);
    wr(3'd6, 8'h10);          // source ch1, ring off
    tick_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      wr(3'd6, 8'h12);
      @(negedge clk); @(negedge clk);
      wr(3'd6, 8'h10);
      @(negedge clk); @(negedge clk);
    end
    chk(lvl[3] == 1'b1, "R10 noise found 1", lvl[3], 1);
    wr(3'd6, 8'h20);          // source ch2 (synced)
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      chk(lvl[3] == 1'b1, "R10 stays 1 on ch2", lvl[3], 1);
    end
    wr(3'd6, 8'h12);
    @(negedge clk);
    chk(lvl[1] == 1'b0, "R7 synced ch1 with noise 1", lvl[1], 0);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk(lvl[3] == 1'b1, "R10 stays 1 ring on", lvl[3], 1);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_freq();
    t_sync();
    t_reload();
    t_ring();
    t_ring_noise();
    t_lfsr();
    t_find_one();
    summary();
  end
endmodule